// File: doc/BRIEF.md
# Three-Counter Performance Monitor

This block counts processor events for profiling. It has one cycle counter and two event counters whose input can be chosen. A single control word sets up all three. A small register bus reads and writes the control word and each counter value. Events arrive as a vector of single-cycle pulses, and an 8-bit code picks which pulse an event counter follows.

All three counters share one master enable, so none of them can be stopped on its own. To park an event counter, software selects a code whose input is held idle. Each counter raises its own overflow flag when it wraps. One interrupt output combines the three flags, each gated by its own enable bit. Software clears the flags by writing ones to them. Writing back a control word that was just read therefore acknowledges every flag that was pending, and leaves the rest of the setup as it was.

Top module: `perf_mon3`

## Requirements
- R1: While control bit 0 (master enable) is 0, no counter advances. While it is 1, every counter may advance.
- R2: Writing 1 to control bit 1 zeroes both event counters. Writing 1 to control bit 2 zeroes the cycle counter and its divider. Both bits read back as 0, and the cycle counter is untouched by bit 1.
- R3: With control bit 3 at 0 the cycle counter advances on every enabled clock. With bit 3 at 1 it advances once per 64 enabled clocks, counted from its last reset.
- R4: Event counter 0 takes its 8-bit select from control bits [27:20], and event counter 1 from bits [19:12]. An enabled counter advances by one in each cycle that the input indexed by its select is high.
- R5: Select code 0x20 never advances a counter, whatever the input at index 0x20 does. Select code 0xFF advances the counter on every enabled cycle.
- R6: Bus address 0 is the control word, 1 the cycle counter, 2 event counter 0 and 3 event counter 1. A written counter value reads back unchanged. A write to a counter takes priority over an increment in the same cycle.
- R7: When a counter wraps from all ones to zero, its overflow flag is set: bit 8 for event counter 0, bit 9 for event counter 1, bit 10 for the cycle counter.
- R8: Writing 1 to an overflow flag clears it, and writing 0 leaves it as it was. A flag that is set in the same cycle as a clear stays set.
- R9: Interrupt enables sit in control bits 4, 5 and 6 (event counter 0, event counter 1, cycle counter). `irq` is high exactly while some flag is set together with its enable.
- R10: After reset the control word, all counters and `irq` are zero. Control bits 7, 11 and 31:28 always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| evt_in | input | 256 | Event pulse vector, indexed by select code |
| irq | output | 1 | Combined overflow interrupt |

## Verification
The bench builds the block with its default parameters: 32-bit counters, 8-bit select codes and a 64-cycle cycle divider. Wrap cases are reached in a few cycles by first loading a counter with a value near all ones over the bus. The 64-cycle divider is short enough that the bench can sample the cycle counter both one clock before and exactly at its first divided step. The same-cycle case where a flag is set while it is being cleared is driven directly by pairing an event pulse with a control write.

// File: rtl/perf_mon3_pkg.sv
// Shared constants for the three-counter performance monitor.
// Assumes a 32-bit register bus and a fixed control word layout.
package perf_mon3_pkg;
    localparam int BUS_W      = 32;
    localparam int SEL_W      = 8;
    localparam int NUM_CNT    = 3;     // index 0: event 0, 1: event 1, 2: cycle
    localparam int B_EN       = 0;
    localparam int B_RST_EV   = 1;
    localparam int B_RST_CYC  = 2;
    localparam int B_DIV      = 3;
    localparam int B_IEN      = 4;     // 4..6
    localparam int B_OVF      = 8;     // 8..10
    localparam int SEL_LSB0   = 20;
    localparam int SEL_LSB1   = 12;
    localparam logic [SEL_W-1:0] IDLE_CODE = 8'h20;
    localparam logic [SEL_W-1:0] CYC_CODE  = 8'hFF;

    typedef enum logic [1:0] {
        ADR_CTRL = 2'd0,
        ADR_CYC  = 2'd1,
        ADR_EV0  = 2'd2,
        ADR_EV1  = 2'd3
    } reg_addr_t;
endpackage

// File: rtl/pmu_evt_sel.sv
// Event selector: turns a select code into a one-cycle hit.
// Assumes the event vector has one entry per possible code; the idle
// code is forced low and the cycle code is forced high.
module pmu_evt_sel #(
    parameter int SEL_W = 8,
    parameter logic [SEL_W-1:0] IDLE_CODE = 8'h20,
    parameter logic [SEL_W-1:0] CYC_CODE  = 8'hFF,
    localparam int NUM_EVT = 1 << SEL_W
) (
    input  logic [SEL_W-1:0]   code_i,
    input  logic [NUM_EVT-1:0] evt_i,
    output logic               hit_o
);
    // Pick the indexed pulse, with the two reserved codes overriding it.
    always_comb begin
        if (code_i == CYC_CODE)       hit_o = 1'b1;
        else if (code_i == IDLE_CODE) hit_o = 1'b0;
        else                          hit_o = evt_i[code_i];
    end
endmodule

// File: rtl/pmu_prescaler.sv
// Cycle divider for the cycle counter. It produces a tick on every enabled
// clock, or on every 2**DIV_LOG2-th enabled clock when div_i is set.
// Assumes clr_i restarts the division phase.
module pmu_prescaler #(
    parameter int DIV_LOG2 = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic div_i,
    input  logic clr_i,
    output logic tick_o
);
    logic [DIV_LOG2-1:0] pre_q;

    // Phase counter: cleared on request, advances while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) pre_q <= '0;
        else if (en_i)       pre_q <= pre_q + 1'b1;
    end

    // Tick output from enable, divide mode and phase.
    assign tick_o = en_i && (!div_i || (&pre_q));

    // R3: in divide mode two ticks never follow each other.
    assert_div_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (div_i && tick_o) |=> (!div_i || !tick_o));
endmodule

// File: rtl/pmu_counter.sv
// One wrapping counter with direct write, clear and increment.
// Priority order: write, then clear, then increment. wrap_o pulses in the
// cycle an increment takes the value from all ones to zero.
module pmu_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    input  logic         clr_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] value_o,
    output logic         wrap_o
);
    logic [W-1:0] value_q;

    // Count register update.
    always_ff @(posedge clk) begin
        if (!rst_n)     value_q <= '0;
        else if (wr_i)  value_q <= wdata_i;
        else if (clr_i) value_q <= '0;
        else if (inc_i) value_q <= value_q + 1'b1;
    end

    // Wrap detection for the overflow flag.
    assign wrap_o  = inc_i && !wr_i && !clr_i && (&value_q);
    assign value_o = value_q;

    // R6: a write lands exactly, whatever the increment does.
    assert_write_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> value_q == $past(wdata_i));
    // R2: a clear without a write leaves zero.
    assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !wr_i) |=> value_q == '0);
    // R1: with no request the value holds.
    assert_hold_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_i && !clr_i && !wr_i) |=> $stable(value_q));
endmodule

// File: rtl/perf_mon3.sv
// Three-counter performance monitor: a cycle counter and two event counters
// behind one control word. Register bus writes take effect at the clock
// edge; reads are combinational. Assumes CNT_W <= 32 and one-cycle event
// pulses on evt_in.
module perf_mon3
    import perf_mon3_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int DIV_LOG2 = 6,
    localparam int NUM_EVT = 1 << SEL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [1:0]         bus_addr,
    input  logic [BUS_W-1:0]   bus_wdata,
    output logic [BUS_W-1:0]   bus_rdata,
    input  logic [NUM_EVT-1:0] evt_in,
    output logic               irq
);
    logic                 ctrl_wr;
    logic                 en_q, div_q;
    logic [NUM_CNT-1:0]   ien_q, ovf_q, wrap;
    logic [SEL_W-1:0]     sel_q [2];
    logic [CNT_W-1:0]     cnt_val [NUM_CNT];
    logic                 cyc_tick;
    logic [BUS_W-1:0]     ctrl_rd;

    assign ctrl_wr = bus_wr && (bus_addr == ADR_CTRL);

    // Plain control fields: enable, divide and interrupt enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            div_q <= 1'b0;
            ien_q <= '0;
        end else if (ctrl_wr) begin
            en_q  <= bus_wdata[B_EN];
            div_q <= bus_wdata[B_DIV];
            ien_q <= bus_wdata[B_IEN +: NUM_CNT];
        end
    end

    // Overflow flags: a write of one clears, and a wrap in the same cycle wins.
    always_ff @(posedge clk) begin
        if (!rst_n) ovf_q <= '0;
        else        ovf_q <= (ovf_q & ~({NUM_CNT{ctrl_wr}} & bus_wdata[B_OVF +: NUM_CNT])) | wrap;
    end

    // Two event counters, each with its own select field and address.
    for (genvar gi = 0; gi < 2; gi++) begin : g_ev
        localparam int               LSB    = (gi == 0) ? SEL_LSB0 : SEL_LSB1;
        localparam logic [1:0]       MY_ADR = (gi == 0) ? ADR_EV0 : ADR_EV1;
        logic hit;

        // Event select field for this counter.
        always_ff @(posedge clk) begin
            if (!rst_n)       sel_q[gi] <= '0;
            else if (ctrl_wr) sel_q[gi] <= bus_wdata[LSB +: SEL_W];
        end

        pmu_evt_sel #(
            .SEL_W(SEL_W), .IDLE_CODE(IDLE_CODE), .CYC_CODE(CYC_CODE)
        ) u_sel (
            .code_i(sel_q[gi]), .evt_i(evt_in), .hit_o(hit)
        );

        pmu_counter #(.W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n),
            .inc_i(en_q && hit),
            .clr_i(ctrl_wr && bus_wdata[B_RST_EV]),
            .wr_i(bus_wr && (bus_addr == MY_ADR)),
            .wdata_i(bus_wdata[CNT_W-1:0]),
            .value_o(cnt_val[gi]),
            .wrap_o(wrap[gi])
        );
    end

    pmu_prescaler #(.DIV_LOG2(DIV_LOG2)) u_pre (
        .clk(clk), .rst_n(rst_n),
        .en_i(en_q), .div_i(div_q),
        .clr_i(ctrl_wr && bus_wdata[B_RST_CYC]),
        .tick_o(cyc_tick)
    );

    pmu_counter #(.W(CNT_W)) u_cyc (
        .clk(clk), .rst_n(rst_n),
        .inc_i(cyc_tick),
        .clr_i(ctrl_wr && bus_wdata[B_RST_CYC]),
        .wr_i(bus_wr && (bus_addr == ADR_CYC)),
        .wdata_i(bus_wdata[CNT_W-1:0]),
        .value_o(cnt_val[2]),
        .wrap_o(wrap[2])
    );

    // Control word image; reset bits and spare bits read as zero.
    always_comb begin
        ctrl_rd                        = '0;
        ctrl_rd[B_EN]                  = en_q;
        ctrl_rd[B_DIV]                 = div_q;
        ctrl_rd[B_IEN +: NUM_CNT]      = ien_q;
        ctrl_rd[B_OVF +: NUM_CNT]      = ovf_q;
        ctrl_rd[SEL_LSB0 +: SEL_W]     = sel_q[0];
        ctrl_rd[SEL_LSB1 +: SEL_W]     = sel_q[1];
    end

    // Read mux by address.
    always_comb begin
        case (bus_addr)
            ADR_CTRL: bus_rdata = ctrl_rd;
            ADR_CYC:  bus_rdata = BUS_W'(cnt_val[2]);
            ADR_EV0:  bus_rdata = BUS_W'(cnt_val[0]);
            default:  bus_rdata = BUS_W'(cnt_val[1]);
        endcase
    end

    // Combined interrupt.
    assign irq = |(ovf_q & ien_q);

    // R1: with the master enable clear and no bus write, the cycle count holds.
    assert_enable_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !bus_wr) |=> $stable(cnt_val[2]));
    for (genvar gk = 0; gk < NUM_CNT; gk++) begin : g_chk
        // R7: a wrap always leaves its flag set.
        assert_wrap_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
            wrap[gk] |=> ovf_q[gk]);
        // R8: a set flag survives unless a one is written to it.
        assert_flag_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (ovf_q[gk] && !(ctrl_wr && bus_wdata[B_OVF + gk])) |=> ovf_q[gk]);
    end
endmodule

// File: tb/perf_mon3_bench.sv
module perf_mon3_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [1:0]   bus_addr = 2'd0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [255:0] evt_in = '0;
    logic         irq;
    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;   // 125 MHz

    perf_mon3 u_perf_mon3 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in), .irq(irq)
    );

    // rows: {select code, pulsed input, pulse count, expected event-0 count}
    localparam logic [31:0] TBL [5] = '{
        32'h05_05_07_07, 32'h05_06_07_00, 32'h20_20_05_00,
        32'hFF_00_09_0A, 32'h11_11_03_03 };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic pulse(input int idx, input int n);
        for (int k = 0; k < n; k++) begin
            evt_in = '0; evt_in[idx] = 1'b1;
            @(posedge clk); @(negedge clk);
            evt_in = '0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        rd(0, v); chk("R10 ctrl reset", v, 32'h0);
        rd(1, v); chk("R10 cyc reset", v, 32'h0);
        rd(2, v); chk("R10 ev0 reset", v, 32'h0);
        rd(3, v); chk("R10 ev1 reset", v, 32'h0);
        chk("R10 irq reset", {31'b0, irq}, 32'h0);

        // R1: disabled counters ignore events and cycles
        wr(0, 32'h0050_3006);
        pulse(5, 3); pulse(3, 3);
        rd(2, v); chk("R1 ev0 disabled", v, 32'h0);
        rd(3, v); chk("R1 ev1 disabled", v, 32'h0);
        rd(1, v); chk("R1 cyc disabled", v, 32'h0);
        rd(0, v); chk("R2 reset bits read 0", v, 32'h0050_3000);

        // R4/R5: table of selects and pulse patterns; cycle counter runs n+1
        foreach (TBL[r]) begin
            base = {4'h0, TBL[r][31:24], 8'h20, 12'h000};
            wr(0, base | 32'h6);
            wr(0, base | 32'h1);
            pulse(TBL[r][23:16], int'(TBL[r][15:8]));
            wr(0, base);
            rd(2, v); chk("R4 R5 table ev0", v, {24'h0, TBL[r][7:0]});
            rd(1, v); chk("R3 table cyc undivided", v, {24'h0, TBL[r][15:8]} + 32'd1);
        end

        // R4: event counter 1 uses bits [19:12]
        wr(0, 32'h0040_3006);
        wr(0, 32'h0040_3001);
        pulse(3, 4);
        wr(0, 32'h0040_3000);
        rd(3, v); chk("R4 ev1 select", v, 32'd4);
        rd(2, v); chk("R4 ev0 unaffected", v, 32'd0);

        // R2/R6: direct writes, reset bits per group
        wr(1, 32'h0000_0055);
        wr(0, 32'h0040_3002);
        rd(3, v); chk("R2 ev1 cleared", v, 32'd0);
        rd(1, v); chk("R2 cyc kept", v, 32'h55);
        wr(0, 32'h0040_3004);
        rd(1, v); chk("R2 cyc cleared", v, 32'd0);
        wr(2, 32'hDEAD_BEEF); rd(2, v); chk("R6 ev0 readback", v, 32'hDEAD_BEEF);
        wr(3, 32'h1234_5678); rd(3, v); chk("R6 ev1 readback", v, 32'h1234_5678);

        // R7/R9: event counter 0 wraps
        wr(2, 32'hFFFF_FFFE);
        wr(0, 32'h0072_0011);
        pulse(7, 2);
        rd(2, v); chk("R7 ev0 wrapped", v, 32'd0);
        rd(0, v); chk("R7 flag bit8", v, 32'h0072_0111);
        chk("R9 irq raised", {31'b0, irq}, 32'h1);

        // R9/R8: mask, write-zero keeps flag, write-one clears
        wr(0, 32'h0072_0001);
        chk("R9 irq masked", {31'b0, irq}, 32'h0);
        rd(0, v); chk("R8 write 0 keeps flag", v, 32'h0072_0101);
        wr(0, 32'h0072_0101);
        rd(0, v); chk("R8 write 1 clears", v, 32'h0072_0001);

        // R6: write beats a same-cycle increment
        wr(0, 32'h0FF2_0001);
        wr(2, 32'h0000_0100);
        rd(2, v); chk("R6 write priority", v, 32'h100);
        wr(0, 32'h0072_0001);

        // R8: set and clear in the same cycle, set wins
        wr(2, 32'hFFFF_FFFF);
        evt_in = '0; evt_in[7] = 1'b1;
        wr(0, 32'h0072_0101);
        evt_in = '0;
        rd(0, v); chk("R8 set beats clear", v, 32'h0072_0101);
        wr(0, 32'h0072_0100);
        rd(0, v); chk("R8 flag cleared", v, 32'h0072_0000);

        // R3: divided cycle counter steps on the 64th enabled clock
        wr(0, 32'h0072_000D);
        repeat (63) @(posedge clk);
        @(negedge clk);
        rd(1, v); chk("R3 div before step", v, 32'd0);
        @(posedge clk); @(negedge clk);
        rd(1, v); chk("R3 div step", v, 32'd1);
        wr(0, 32'h0072_0000);

        // R7/R9: cycle counter wraps
        wr(1, 32'hFFFF_FFFF);
        wr(0, 32'h0072_0041);
        @(posedge clk); @(negedge clk);
        rd(0, v); chk("R7 cyc flag bit10", v, 32'h0072_0441);
        chk("R9 irq cyc", {31'b0, irq}, 32'h1);
        wr(0, 32'h0072_0400);
        chk("R9 irq after clear", {31'b0, irq}, 32'h0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule